// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block holds the software-visible control state of one bus-master DMA channel for an ATA disk port. Software writes a command byte, a status byte and a 32-bit pointer to a descriptor table over a simple register bus with byte enables. The block turns those writes into start, cancel and direction controls for a separate descriptor walker. It also keeps a live copy of the table pointer that the walker starts from, and it tracks whether a transfer is in flight.

The disk's interrupt line passes through the block to the host. On its rising edge the block latches an interrupt flag in status. The walker reports the end of each transfer with a done event that can carry an error flag and a "more to come" flag. Software clears the error and interrupt flags by writing ones to them.

Register map: word 0 holds the command byte in byte lane 0 and the status byte in byte lane 2. Word 1 holds the table pointer. Reads return the whole word in the same layout, with unused bits reading as zero.

Top module: `busmaster_dma_regs`

## Requirements
- R1: After reset, both read words are zero, and `start_o`, `dir_o`, `active`, `kick`, `cancel`, `host_irq`, `tbl_base` and `cur_ptr` are all zero.
- R2: A command write (word 0, lane 0) keeps only bit 0 (start) and bit 3 (direction), so the command byte reads back as the written byte AND 0x09. `start_o` and `dir_o` show those two bits.
- R3: A command write that changes start from 0 to 1 copies `tbl_base` into `cur_ptr` and sets status bit 0 (active). If active was clear, it also raises `kick` for exactly one cycle. All three become visible in the cycle after the write edge.
- R4: A command write whose start bit equals the stored start bit takes no start action: no `kick`, no `cancel`, no reload of `cur_ptr`, and no change to active.
- R5: A command write that changes start from 1 to 0 clears active and raises `cancel` for exactly one cycle.
- R6: A status write (word 0, lane 2) loads status bits 5 and 6 from the written byte. Active (bit 0) is unchanged by the write.
- R7: In a status write, a 1 in bit 1 clears the error flag and a 1 in bit 2 clears the interrupt flag. A 0 in either bit leaves that flag as it was.
- R8: A table-pointer write (word 1) updates only the byte lanes whose enable is set. Bits 1:0 of the pointer always read as zero.
- R9: A rising edge on `drive_irq` sets status bit 2 (interrupt). `host_irq` follows `drive_irq` one cycle later at both levels. A falling edge leaves status unchanged.
- R10: A done event with `xfer_more` low clears active; with `xfer_more` high, active stays set. A done event with `xfer_err` high sets status bit 1 (error).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select for writes: 0 command/status, 1 table pointer |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte-lane enables for writes |
| rd_addr | input | 1 | Word select for reads |
| rd_data | output | 32 | Read data for the selected word |
| drive_irq | input | 1 | Interrupt level from the disk |
| xfer_done | input | 1 | One-cycle pulse from the walker at the end of a transfer |
| xfer_more | input | 1 | With done: more of the transfer is pending |
| xfer_err | input | 1 | With done: the transfer hit an error |
| start_o | output | 1 | Stored start bit |
| dir_o | output | 1 | Stored direction bit |
| kick | output | 1 | One-cycle pulse: begin walking the table |
| cancel | output | 1 | One-cycle pulse: abort the transfer |
| active | output | 1 | Transfer-in-flight flag (status bit 0) |
| tbl_base | output | 32 | Table base pointer, dword aligned |
| cur_ptr | output | 32 | Current table pointer, loaded from the base on start |
| host_irq | output | 1 | Interrupt level forwarded to the host |

## Verification
The hardest case to reach from the ports is a start write that repeats the stored value after the base has moved. Only an unchanged `cur_ptr` and a silent `kick` show that the write did nothing. The directed sequence rewrites the base between two start-set writes to expose that case. A second directed sequence puts a done event with the continuation flag and a done event with an error into the same run, then clears the error with a write-one while bits 5 and 6 change in the same byte. Random pointer writes with random lane enables and random status writes are compared with a bench model of the lane merge and the user bits.

// File: rtl/busmaster_dma_pkg.sv
package busmaster_dma_pkg;

    localparam int CMD_START_POS = 0;
    localparam int CMD_DIR_POS   = 3;

    typedef struct packed {
        logic dir;
        logic start;
    } cmd_t;

    typedef struct packed {
        logic [1:0] user;
        logic       irq;
        logic       err;
        logic       active;
    } stat_t;

    function automatic logic [7:0] cmd_to_byte(cmd_t c);
        logic [7:0] b;
        b = 8'h00;
        b[CMD_START_POS] = c.start;
        b[CMD_DIR_POS]   = c.dir;
        return b;
    endfunction

    function automatic logic [7:0] stat_to_byte(stat_t s);
        return {1'b0, s.user, 2'b00, s.irq, s.err, s.active};
    endfunction

endpackage

// File: rtl/bm_cmd_ctl.sv
module bm_cmd_ctl
    import busmaster_dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_cmd,
    input  logic new_start,
    input  logic new_dir,
    input  logic active_i,
    output cmd_t cmd,
    output logic start_set,
    output logic start_clr,
    output logic kick,
    output logic cancel
);
    logic edge_hit;

    always_comb begin
        edge_hit  = wr_cmd && (new_start != cmd.start);
        start_set = edge_hit && new_start;
        start_clr = edge_hit && !new_start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd    <= '0;
            kick   <= 1'b0;
            cancel <= 1'b0;
        end else begin
            if (wr_cmd) begin
                cmd.start <= new_start;
                cmd.dir   <= new_dir;
            end
            kick   <= start_set && !active_i;
            cancel <= start_clr;
        end
    end
endmodule

// File: rtl/bm_tbl_ptr.sv
module bm_tbl_ptr #(
    parameter int PTR_W      = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ptr,
    input  logic [PTR_W-1:0]   wdata,
    input  logic [PTR_W/8-1:0] be,
    input  logic               reload,
    output logic [PTR_W-1:0]   base,
    output logic [PTR_W-1:0]   cur
);
    localparam int LANES = PTR_W / 8;

    logic [PTR_W-1:0] merged;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : base[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            cur  <= '0;
        end else begin
            if (wr_ptr) begin
                base <= {merged[PTR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
            end
            if (reload) begin
                cur <= base;
            end
        end
    end
endmodule

// File: rtl/bm_stat_regs.sv
module bm_stat_regs
    import busmaster_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stat,
    input  logic [1:0] w_user,
    input  logic       w_clr_err,
    input  logic       w_clr_irq,
    input  logic       start_set,
    input  logic       start_clr,
    input  logic       done,
    input  logic       more,
    input  logic       err_in,
    input  logic       irq_rise,
    output stat_t      stat
);
    stat_t nxt;

    always_comb begin
        nxt = stat;
        if (done && !more) nxt.active = 1'b0;
        if (start_clr)     nxt.active = 1'b0;
        if (start_set)     nxt.active = 1'b1;
        if (wr_stat) begin
            nxt.user = w_user;
            if (w_clr_err) nxt.err = 1'b0;
            if (w_clr_irq) nxt.irq = 1'b0;
        end
        if (done && err_in) nxt.err = 1'b1;
        if (irq_rise)       nxt.irq = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) stat <= '0;
        else     stat <= nxt;
    end
endmodule

// File: rtl/busmaster_dma_regs.sv
module busmaster_dma_regs
    import busmaster_dma_pkg::*;
#(
    parameter int PTR_W      = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [PTR_W-1:0]   reg_wdata,
    input  logic [PTR_W/8-1:0] reg_be,
    input  logic               rd_addr,
    output logic [PTR_W-1:0]   rd_data,
    input  logic               drive_irq,
    input  logic               xfer_done,
    input  logic               xfer_more,
    input  logic               xfer_err,
    output logic               start_o,
    output logic               dir_o,
    output logic               kick,
    output logic               cancel,
    output logic               active,
    output logic [PTR_W-1:0]   tbl_base,
    output logic [PTR_W-1:0]   cur_ptr,
    output logic               host_irq
);
    localparam int STAT_LO = 16;

    cmd_t  cmd_q;
    stat_t stat_q;
    logic  start_set, start_clr;
    logic  wr_cmd, wr_stat, wr_ptr;
    logic  irq_rise;
    logic  irq_flag;

    assign wr_cmd   = reg_wr && !reg_addr && reg_be[0];
    assign wr_stat  = reg_wr && !reg_addr && reg_be[2];
    assign wr_ptr   = reg_wr && reg_addr;
    assign irq_rise = drive_irq && !host_irq;

    always_ff @(posedge clk) begin
        if (rst) host_irq <= 1'b0;
        else     host_irq <= drive_irq;
    end

    bm_cmd_ctl u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (wr_cmd),
        .new_start (reg_wdata[CMD_START_POS]),
        .new_dir   (reg_wdata[CMD_DIR_POS]),
        .active_i  (stat_q.active),
        .cmd       (cmd_q),
        .start_set (start_set),
        .start_clr (start_clr),
        .kick      (kick),
        .cancel    (cancel)
    );

    bm_stat_regs u_stat (
        .clk       (clk),
        .rst       (rst),
        .wr_stat   (wr_stat),
        .w_user    (reg_wdata[STAT_LO+6:STAT_LO+5]),
        .w_clr_err (reg_wdata[STAT_LO+1]),
        .w_clr_irq (reg_wdata[STAT_LO+2]),
        .start_set (start_set),
        .start_clr (start_clr),
        .done      (xfer_done),
        .more      (xfer_more),
        .err_in    (xfer_err),
        .irq_rise  (irq_rise),
        .stat      (stat_q)
    );

    bm_tbl_ptr #(.PTR_W(PTR_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .wr_ptr (wr_ptr),
        .wdata  (reg_wdata),
        .be     (reg_be),
        .reload (start_set),
        .base   (tbl_base),
        .cur    (cur_ptr)
    );

    assign start_o  = cmd_q.start;
    assign dir_o    = cmd_q.dir;
    assign active   = stat_q.active;
    assign irq_flag = stat_q.irq;

    always_comb begin
        rd_data = '0;
        if (rd_addr) begin
            rd_data = tbl_base;
        end else begin
            rd_data[7:0]               = cmd_to_byte(cmd_q);
            rd_data[STAT_LO +: 8]      = stat_to_byte(stat_q);
        end
    end
endmodule

// File: rtl/busmaster_dma_regs_chk.sv
module busmaster_dma_regs_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             drive_irq,
    input logic             host_irq,
    input logic             kick,
    input logic             cancel,
    input logic             active,
    input logic             start_o,
    input logic             irq_flag,
    input logic [PTR_W-1:0] tbl_base
);
    logic seen;
    always_ff @(posedge clk) seen <= !rst;

    AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (rst) kick |=> !kick); // R3
    AST_KICK_ACTIVE: assert property (@(posedge clk) disable iff (rst) kick |-> (active && start_o)); // R3
    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (rst) cancel |-> (!active && !start_o)); // R5
    AST_NO_KICK_CANCEL: assert property (@(posedge clk) disable iff (rst) !(kick && cancel)); // R4
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst) tbl_base[1:0] == 2'b00); // R8
    AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (rst || !seen) host_irq == $past(drive_irq)); // R9
    AST_IRQ_LATCH: assert property (@(posedge clk) disable iff (rst || !seen) (drive_irq && !host_irq) |=> irq_flag); // R9
endmodule

bind busmaster_dma_regs busmaster_dma_regs_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .drive_irq (drive_irq),
    .host_irq  (host_irq),
    .kick      (kick),
    .cancel    (cancel),
    .active    (active),
    .start_o   (start_o),
    .irq_flag  (irq_flag),
    .tbl_base  (tbl_base)
);

// File: tb/busmaster_dma_regs_bench.sv
`timescale 1ns/1ps
module busmaster_dma_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_be = '0;
    logic        rd_addr = 1'b0;
    logic [31:0] rd_data;
    logic        drive_irq = 1'b0, xfer_done = 1'b0, xfer_more = 1'b0, xfer_err = 1'b0;
    logic        start_o, dir_o, kick, cancel, active, host_irq;
    logic [31:0] tbl_base, cur_ptr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    busmaster_dma_regs u_busmaster_dma_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .rd_addr(rd_addr), .rd_data(rd_data),
        .drive_irq(drive_irq), .xfer_done(xfer_done), .xfer_more(xfer_more),
        .xfer_err(xfer_err), .start_o(start_o), .dir_o(dir_o), .kick(kick),
        .cancel(cancel), .active(active), .tbl_base(tbl_base), .cur_ptr(cur_ptr),
        .host_irq(host_irq)
    );

    function automatic logic [31:0] model_ptr(logic [31:0] old, logic [31:0] d, logic [3:0] be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? d[i*8 +: 8] : old[i*8 +: 8];
        return r & 32'hFFFF_FFFC;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic done_ev(logic more, logic err);
        @(negedge clk);
        xfer_done = 1'b1; xfer_more = more; xfer_err = err;
        @(posedge clk); #1;
        xfer_done = 1'b0; xfer_more = 1'b0; xfer_err = 1'b0;
    endtask

    task automatic set_irq(logic v);
        @(negedge clk);
        drive_irq = v;
        @(posedge clk); #1;
    endtask

    task automatic rd(logic a, output logic [31:0] d);
        rd_addr = a; #0.5; d = rd_data;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d, mptr;
        logic [1:0]  muser;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        rd(1'b0, d); check("R1 word0", d, 32'h0);
        rd(1'b1, d); check("R1 word1", d, 32'h0);
        check("R1 outputs", {start_o, dir_o, active, kick, cancel, host_irq}, 32'h0);
        check("R1 cur_ptr", cur_ptr, 32'h0);

        // R8 pointer full and partial writes, low bits forced zero
        wr(1'b1, 32'h1234_5677, 4'hF);
        rd(1'b1, d); check("R8 full write", d, 32'h1234_5674);
        wr(1'b1, 32'hFFFF_AB03, 4'b0010);
        rd(1'b1, d); check("R8 lane1 only", d, 32'h1234_AB74);

        // R2/R3 command masking and start rising
        wr(1'b0, 32'h0000_00FF, 4'b0001);
        check("R3 kick pulse", kick, 1'b1);
        check("R3 active set", active, 1'b1);
        check("R3 cur reload", cur_ptr, 32'h1234_AB74);
        rd(1'b0, d); check("R2 cmd mask", d & 32'hFF, 32'h09);
        check("R2 start/dir", {start_o, dir_o}, 2'b11);
        @(posedge clk); #1;
        check("R3 kick one cycle", kick, 1'b0);

        // R4 same start value, new base: nothing happens
        wr(1'b1, 32'h0000_1000, 4'hF);
        wr(1'b0, 32'h0000_0001, 4'b0001);
        check("R4 no kick", {kick, cancel}, 2'b00);
        check("R4 cur kept", cur_ptr, 32'h1234_AB74);
        check("R4 active kept", active, 1'b1);
        check("R2 dir cleared", dir_o, 1'b0);

        // R10 done events
        done_ev(1'b1, 1'b0);
        check("R10 more keeps active", active, 1'b1);
        done_ev(1'b0, 1'b1);
        check("R10 done clears active", active, 1'b0);
        rd(1'b0, d); check("R10 error set", d[17], 1'b1);

        // R6/R7 status write: user bits, error kept on 0
        wr(1'b0, 32'h0061_0000, 4'b0100);
        rd(1'b0, d); check("R6 user bits and active", d[23:16], 8'h62);
        wr(1'b0, 32'h0002_0000, 4'b0100);
        rd(1'b0, d); check("R7 error w1c", d[23:16], 8'h00);

        // R9 interrupt pass-through
        set_irq(1'b1);
        check("R9 host_irq high", host_irq, 1'b1);
        rd(1'b0, d); check("R9 irq latched", d[18], 1'b1);
        set_irq(1'b0);
        check("R9 host_irq low", host_irq, 1'b0);
        rd(1'b0, d); check("R9 fall keeps flag", d[18], 1'b1);
        wr(1'b0, 32'h0000_0000, 4'b0100);
        rd(1'b0, d); check("R7 zero keeps irq", d[18], 1'b1);
        wr(1'b0, 32'h0004_0000, 4'b0100);
        rd(1'b0, d); check("R7 irq w1c", d[18], 1'b0);

        // R5 cancel after restart
        wr(1'b0, 32'h0000_0000, 4'b0001);
        check("R5 cancel on clear", cancel, 1'b1);
        wr(1'b0, 32'h0000_0001, 4'b0001);
        check("R3 restart kick", kick, 1'b1);
        check("R3 restart cur", cur_ptr, 32'h0000_1000);
        wr(1'b0, 32'h0000_0000, 4'b0001);
        check("R5 cancel pulse", cancel, 1'b1);
        check("R5 active cleared", active, 1'b0);
        @(posedge clk); #1;
        check("R5 cancel one cycle", cancel, 1'b0);

        // R6 active bit not writable
        wr(1'b0, 32'h0001_0000, 4'b0100);
        check("R6 active not written", active, 1'b0);

        // Random pointer and status traffic
        mptr = 32'h0000_1000; muser = 2'b00;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] rdat;
            logic [3:0]  rbe;
            rdat = $urandom; rbe = 4'($urandom);
            if ($urandom % 2) begin
                wr(1'b1, rdat, rbe);
                mptr = model_ptr(mptr, rdat, rbe);
                rd(1'b1, d); check("R8 random ptr", d, mptr);
            end else begin
                wr(1'b0, rdat & 32'h0060_0000, 4'b0100);
                muser = rdat[22:21];
                rd(1'b0, d); check("R6 random user", d, {8'h0, 1'b0, muser, 5'b0, 16'h0});
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule